// File: doc/BRIEF.md
# Strobed Serial Register-Access Slave

This block is the device side of a slow, four-wire register link that a host drives entirely by toggling general-purpose pins. The host has no clock and no chip-select. It opens each access by pulling an active-low clear line low and then releasing it. It then clocks bits with rising edges of a strobe line: first an 8-bit address frame and then a 16-bit data frame. A serial data input carries bits from host to slave, and a serial data output carries read data back. All three host lines are slow and asynchronous. Each passes through a two-flop synchroniser into the system clock, and strobe edges are detected on the synchronised copy.

The most significant bit of the address frame selects the direction: 1 reads, 0 writes. The low seven bits give the register. A write is committed only when the host sends one extra strobe cycle after the data bits. An access that is cut short by a new clear, or that is simply abandoned, leaves every register untouched. The register file holds two read-only identification words and three kinds of read/write banks. The function-enable banks drive LED and platform enable lines. The GPIO enable banks choose whether each header line is in high impedance or enabled. The GPIO direction banks choose whether each line is driven by the SoC or by the FPGA. Every bank is exported on output ports so that the header routing logic can use it.

Top module: `strobed_reg_slave`

## Requirements
- R1: While reset is applied and on the first cycle after it, every bank output is 0 (all header lines in high impedance) and the serial output is low.
- R2: A write sends address bit 7 = 0 followed by 16 data bits, MSB first, one bit per strobe rising edge. Once the trailing strobe cycle arrives, the addressed bank takes the data. Function-enable banks are at 0x20 + i.
- R3: A write that lacks the trailing strobe cycle, because a new clear cut it off, changes no register.
- R4: A read sends address bit 7 = 1. The slave then presents the register value MSB first. Each bit is valid on the serial output after the strobe rising edge on which the host samples it, so bit 15 is valid after the first rising edge following the address frame.
- R5: Address 0x10 reads {board ID, 0x01}. Address 0x11 reads {build, 4'h0, minor, patch} in nibbles 15:12, 11:8, 7:4 and 3:0, so the major field is always 0.
- R6: Writes to 0x10, 0x11 or to any unmapped address are ignored. Reads of unmapped addresses return 0x0000.
- R7: Strobe edges that arrive after the trailing cycle, or before any clear since reset, have no effect until the next clear.
- R8: The serial output stays low except during the data phase of a read.
- R9: GPIO enable bank i is at 0x30 + i and GPIO direction bank i is at 0x40 + i. Bank i drives bits [16i+15:16i] of its output port. An enable bit of 1 enables the line, and a direction bit of 1 makes the line FPGA-driven.
- R10: A clear in the middle of a frame resets the bit counters, and the access that follows it runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n_i | input | 1 | Host clear line, pulsed low to open an access (asynchronous) |
| stb_i | input | 1 | Host strobe; rising edges clock bits (asynchronous) |
| sdi_i | input | 1 | Serial data from host (asynchronous) |
| sdo_o | output | 1 | Serial read data to host |
| func_en_o | output | FEN_BANKS*16 | Function-enable banks, bank i in bits [16i+15:16i] |
| gpio_en_o | output | GPIO_BANKS*16 | GPIO enable banks: 0 = high impedance, 1 = enabled |
| gpio_dir_o | output | GPIO_BANKS*16 | GPIO direction banks: 0 = SoC-driven, 1 = FPGA-driven |

## Verification
The bench keeps the default bank counts, two function-enable banks and three GPIO banks. With these counts every mapped bank address has a neighbour that is unmapped (0x22, 0x33, 0x43), so decode holes around each bank can be reached. The bench overrides the board ID to 0xA5 and the firmware nibbles to build 3, minor 4 and patch 7. Every field of both identification words is therefore distinct and non-zero apart from the major nibble, which makes a swapped or shifted field visible on readback. Random accesses mix reads, full writes and truncated writes over mapped and unmapped addresses, and they are checked against a bench model of the register file.

// File: rtl/strobed_reg_pkg.sv
package strobed_reg_pkg;

    localparam int REG_W     = 16;
    localparam int FRAME_AW  = 8;
    localparam int REG_AW    = FRAME_AW - 1;
    localparam int SYNC_DEPTH = 2;

    localparam logic [REG_AW-1:0] ADR_PLATFORM = 7'h10;
    localparam logic [REG_AW-1:0] ADR_FIRMWARE = 7'h11;
    localparam logic [REG_AW-1:0] ADR_FEN_BASE = 7'h20;
    localparam logic [REG_AW-1:0] ADR_GEN_BASE = 7'h30;
    localparam logic [REG_AW-1:0] ADR_DIR_BASE = 7'h40;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_LOAD,
        PH_WDATA,
        PH_RDATA,
        PH_TRAIL
    } phase_e;

    typedef struct packed {
        logic              rd;
        logic [REG_AW-1:0] reg_adr;
    } addr_frame_t;

    typedef struct packed {
        logic              en;
        logic [REG_AW-1:0] adr;
        logic [REG_W-1:0]  data;
    } wr_req_t;

    function automatic logic [REG_W-1:0] fw_word(input logic [3:0] build,
                                                 input logic [3:0] minor,
                                                 input logic [3:0] patch);
        return {build, 4'h0, minor, patch};
    endfunction

    function automatic logic in_bank(input logic [REG_AW-1:0] adr,
                                     input logic [REG_AW-1:0] base,
                                     input int idx);
        return adr == base + REG_AW'(idx);
    endfunction

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/srs_frame.sv
module srs_frame
    import strobed_reg_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_s,
    input  logic                stb_rise,
    input  logic                stb_fall,
    input  logic                sdi_s,
    input  logic [DATA_W-1:0]   rd_word,
    output logic [REG_AW-1:0]   rd_adr,
    output logic                rd_active,
    output logic                sdo,
    output wr_req_t             wr_req
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(FRAME_AW - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] DATA_ALL  = CNT_W'(DATA_W);

    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    addr_frame_t       frame;
    logic [DATA_W-1:0] shreg;
    logic              commit;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            frame  <= '0;
            shreg  <= '0;
            commit <= 1'b0;
        end else if (!clr_s) begin
            phase  <= PH_ADDR;
            cnt    <= '0;
            frame  <= '0;
            shreg  <= '0;
            commit <= 1'b0;
        end else begin
            commit <= 1'b0;
            unique case (phase)
                PH_ADDR: if (stb_rise) begin
                    frame <= {frame[FRAME_AW-2:0], sdi_s};
                    if (cnt == ADDR_LAST) begin
                        cnt   <= '0;
                        phase <= PH_LOAD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_LOAD: begin
                    if (frame.rd) begin
                        shreg <= rd_word;
                        phase <= PH_RDATA;
                    end else begin
                        phase <= PH_WDATA;
                    end
                end
                PH_WDATA: if (stb_rise) begin
                    shreg <= {shreg[DATA_W-2:0], sdi_s};
                    if (cnt == DATA_LAST) begin
                        cnt   <= '0;
                        phase <= PH_TRAIL;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_RDATA: begin
                    if (stb_rise && cnt != DATA_ALL) begin
                        cnt <= cnt + 1'b1;
                    end else if (stb_fall && cnt != '0) begin
                        if (cnt == DATA_ALL) begin
                            cnt   <= '0;
                            phase <= PH_TRAIL;
                        end else begin
                            shreg <= {shreg[DATA_W-2:0], 1'b0};
                        end
                    end
                end
                PH_TRAIL: if (stb_rise) begin
                    commit <= !frame.rd;
                    phase  <= PH_IDLE;
                end
                default: ;
            endcase
        end
    end

    assign rd_adr      = frame.reg_adr;
    assign rd_active   = (phase == PH_RDATA);
    assign sdo         = rd_active & shreg[DATA_W-1];
    assign wr_req.en   = commit;
    assign wr_req.adr  = frame.reg_adr;
    assign wr_req.data = shreg;

endmodule

// File: rtl/srs_regs.sv
module srs_regs
    import strobed_reg_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int FEN_BANKS = 2,
    parameter int GPIO_BANKS = 3,
    parameter logic [7:0] BOARD_ID = 8'h00,
    parameter logic [7:0] MAKER_ID = 8'h01,
    parameter logic [3:0] FW_BUILD = 4'h0,
    parameter logic [3:0] FW_MINOR = 4'h0,
    parameter logic [3:0] FW_PATCH = 4'h0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  wr_req_t                       wr_req,
    input  logic [REG_AW-1:0]             rd_adr,
    output logic [DATA_W-1:0]             rd_word,
    output logic [FEN_BANKS*DATA_W-1:0]   fen_o,
    output logic [GPIO_BANKS*DATA_W-1:0]  gen_o,
    output logic [GPIO_BANKS*DATA_W-1:0]  gdir_o
);

    localparam logic [DATA_W-1:0] PLAT_WORD = DATA_W'({BOARD_ID, MAKER_ID});
    localparam logic [DATA_W-1:0] FW_WORD   = DATA_W'(fw_word(FW_BUILD, FW_MINOR, FW_PATCH));

    logic [DATA_W-1:0] fen_q  [FEN_BANKS];
    logic [DATA_W-1:0] gen_q  [GPIO_BANKS];
    logic [DATA_W-1:0] gdir_q [GPIO_BANKS];

    for (genvar i = 0; i < FEN_BANKS; i++) begin : g_fen
        always_ff @(posedge clk) begin
            if (rst) fen_q[i] <= '0;
            else if (wr_req.en && in_bank(wr_req.adr, ADR_FEN_BASE, i))
                fen_q[i] <= wr_req.data[DATA_W-1:0];
        end
        assign fen_o[i*DATA_W +: DATA_W] = fen_q[i];
    end

    for (genvar i = 0; i < GPIO_BANKS; i++) begin : g_gpio
        always_ff @(posedge clk) begin
            if (rst) begin
                gen_q[i]  <= '0;
                gdir_q[i] <= '0;
            end else if (wr_req.en) begin
                if (in_bank(wr_req.adr, ADR_GEN_BASE, i)) gen_q[i] <= wr_req.data[DATA_W-1:0];
                if (in_bank(wr_req.adr, ADR_DIR_BASE, i)) gdir_q[i] <= wr_req.data[DATA_W-1:0];
            end
        end
        assign gen_o[i*DATA_W +: DATA_W]  = gen_q[i];
        assign gdir_o[i*DATA_W +: DATA_W] = gdir_q[i];
    end

    always_comb begin
        rd_word = '0;
        if (rd_adr == ADR_PLATFORM) rd_word = PLAT_WORD;
        if (rd_adr == ADR_FIRMWARE) rd_word = FW_WORD;
        for (int i = 0; i < FEN_BANKS; i++)
            if (in_bank(rd_adr, ADR_FEN_BASE, i)) rd_word = fen_q[i];
        for (int i = 0; i < GPIO_BANKS; i++) begin
            if (in_bank(rd_adr, ADR_GEN_BASE, i)) rd_word = gen_q[i];
            if (in_bank(rd_adr, ADR_DIR_BASE, i)) rd_word = gdir_q[i];
        end
    end

endmodule

// File: rtl/strobed_reg_slave.sv
module strobed_reg_slave
    import strobed_reg_pkg::*;
#(
    parameter int FEN_BANKS = 2,
    parameter int GPIO_BANKS = 3,
    parameter logic [7:0] BOARD_ID = 8'h00,
    parameter logic [7:0] MAKER_ID = 8'h01,
    parameter logic [3:0] FW_BUILD = 4'h0,
    parameter logic [3:0] FW_MINOR = 4'h0,
    parameter logic [3:0] FW_PATCH = 4'h0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr_n_i,
    input  logic                         stb_i,
    input  logic                         sdi_i,
    output logic                         sdo_o,
    output logic [FEN_BANKS*REG_W-1:0]   func_en_o,
    output logic [GPIO_BANKS*REG_W-1:0]  gpio_en_o,
    output logic [GPIO_BANKS*REG_W-1:0]  gpio_dir_o
);

    logic [2:0]        pins_s;
    logic              clr_s, stb_s, sdi_s, stb_q;
    logic              stb_rise, stb_fall;
    logic [REG_W-1:0]  rd_word;
    logic [REG_AW-1:0] rd_adr;
    logic              rd_active;
    wr_req_t           wr_req;
    logic              wr_commit;

    srs_sync #(.WIDTH(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({clr_n_i, stb_i, sdi_i}),
        .q   (pins_s)
    );

    assign {clr_s, stb_s, sdi_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) stb_q <= 1'b0;
        else     stb_q <= stb_s;
    end

    assign stb_rise = stb_s & ~stb_q;
    assign stb_fall = ~stb_s & stb_q;

    srs_frame #(.DATA_W(REG_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .clr_s     (clr_s),
        .stb_rise  (stb_rise),
        .stb_fall  (stb_fall),
        .sdi_s     (sdi_s),
        .rd_word   (rd_word),
        .rd_adr    (rd_adr),
        .rd_active (rd_active),
        .sdo       (sdo_o),
        .wr_req    (wr_req)
    );

    assign wr_commit = wr_req.en;

    srs_regs #(
        .DATA_W     (REG_W),
        .FEN_BANKS  (FEN_BANKS),
        .GPIO_BANKS (GPIO_BANKS),
        .BOARD_ID   (BOARD_ID),
        .MAKER_ID   (MAKER_ID),
        .FW_BUILD   (FW_BUILD),
        .FW_MINOR   (FW_MINOR),
        .FW_PATCH   (FW_PATCH)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .rd_adr  (rd_adr),
        .rd_word (rd_word),
        .fen_o   (func_en_o),
        .gen_o   (gpio_en_o),
        .gdir_o  (gpio_dir_o)
    );

endmodule

// File: rtl/strobed_reg_slave_chk.sv
module strobed_reg_slave_chk #(
    parameter int FEN_W = 32,
    parameter int GPIO_W = 48
) (
    input logic              clk,
    input logic              rst,
    input logic              clr_s,
    input logic              rd_active,
    input logic              wr_commit,
    input logic              sdo_o,
    input logic [FEN_W-1:0]  func_en_o,
    input logic [GPIO_W-1:0] gpio_en_o,
    input logic [GPIO_W-1:0] gpio_dir_o
);

    a_r1_reset_clean: assert property (@(posedge clk)
        rst |=> (func_en_o == '0 && gpio_en_o == '0 && gpio_dir_o == '0 && !sdo_o));

    a_r2_change_on_commit: assert property (@(posedge clk) disable iff (rst)
        !wr_commit |=> $stable({func_en_o, gpio_en_o, gpio_dir_o}));

    a_r3_commit_inside_access: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> $past(clr_s));

    a_r7_single_commit: assert property (@(posedge clk) disable iff (rst)
        wr_commit |=> !wr_commit);

    a_r8_sdo_quiet: assert property (@(posedge clk) disable iff (rst)
        !rd_active |-> !sdo_o);

endmodule

bind strobed_reg_slave strobed_reg_slave_chk #(
    .FEN_W  (FEN_BANKS * strobed_reg_pkg::REG_W),
    .GPIO_W (GPIO_BANKS * strobed_reg_pkg::REG_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_s      (clr_s),
    .rd_active  (rd_active),
    .wr_commit  (wr_commit),
    .sdo_o      (sdo_o),
    .func_en_o  (func_en_o),
    .gpio_en_o  (gpio_en_o),
    .gpio_dir_o (gpio_dir_o)
);

// File: tb/strobed_reg_slave_tb.sv
module strobed_reg_slave_tb;

    localparam int HOLD = 6;
    localparam logic [7:0] T_BOARD = 8'hA5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr_n = 1'b1, stb = 1'b0, sdi = 1'b0;
    logic sdo;
    logic [31:0] fen;
    logic [47:0] gen, gdir;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] m_fen [2];
    logic [15:0] m_gen [3];
    logic [15:0] m_dir [3];

    always #2.5 clk = ~clk;

    strobed_reg_slave #(
        .BOARD_ID (T_BOARD), .FW_BUILD (4'h3), .FW_MINOR (4'h4), .FW_PATCH (4'h7)
    ) u_dut (
        .clk (clk), .rst (rst), .clr_n_i (clr_n), .stb_i (stb), .sdi_i (sdi),
        .sdo_o (sdo), .func_en_o (fen), .gpio_en_o (gen), .gpio_dir_o (gdir)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [6:0] a);
        case (a)
            7'h10: return {T_BOARD, 8'h01};
            7'h11: return 16'h3047;
            7'h20: return m_fen[0];
            7'h21: return m_fen[1];
            7'h30: return m_gen[0];
            7'h31: return m_gen[1];
            7'h32: return m_gen[2];
            7'h40: return m_dir[0];
            7'h41: return m_dir[1];
            7'h42: return m_dir[2];
            default: return 16'h0000;
        endcase
    endfunction

    function automatic void model_write(input logic [6:0] a, input logic [15:0] d);
        case (a)
            7'h20: m_fen[0] = d;
            7'h21: m_fen[1] = d;
            7'h30: m_gen[0] = d;
            7'h31: m_gen[1] = d;
            7'h32: m_gen[2] = d;
            7'h40: m_dir[0] = d;
            7'h41: m_dir[1] = d;
            7'h42: m_dir[2] = d;
            default: ;
        endcase
    endfunction

    task automatic check_outputs(input string req);
        chk({req, " fen"},  {32'h0, fen},  {32'h0, m_fen[1], m_fen[0]});
        chk({req, " gen"},  {16'h0, gen},  {16'h0, m_gen[2], m_gen[1], m_gen[0]});
        chk({req, " gdir"}, {16'h0, gdir}, {16'h0, m_dir[2], m_dir[1], m_dir[0]});
    endtask

    task automatic strobe_bit(input logic b);
        @(negedge clk);
        stb = 1'b0;
        sdi = b;
        repeat (HOLD) @(negedge clk);
        stb = 1'b1;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic open_access();
        @(negedge clk);
        clr_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        clr_n = 1'b1;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic send_addr(input logic rd, input logic [6:0] a);
        logic [7:0] f;
        f = {rd, a};
        for (int i = 7; i >= 0; i--) strobe_bit(f[i]);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [15:0] d, input bit trail);
        bit sdo_seen;
        sdo_seen = 1'b0;
        open_access();
        send_addr(1'b0, a);
        for (int i = 15; i >= 0; i--) begin
            strobe_bit(d[i]);
            if (sdo) sdo_seen = 1'b1;
        end
        if (trail) begin
            strobe_bit(1'b0);
            model_write(a, d);
        end
        repeat (HOLD) @(negedge clk);
        chk("R8 sdo low in write", {63'h0, sdo_seen}, 64'h0);
    endtask

    task automatic do_read(input logic [6:0] a, input string req);
        logic [15:0] got;
        open_access();
        send_addr(1'b1, a);
        for (int i = 15; i >= 0; i--) begin
            strobe_bit(1'b0);
            got[i] = sdo;
        end
        strobe_bit(1'b0);
        chk(req, {48'h0, got}, {48'h0, exp_read(a)});
        chk("R8 sdo low after read", {63'h0, sdo}, 64'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [6:0] pool [15];
        pool = '{7'h10, 7'h11, 7'h20, 7'h21, 7'h30, 7'h31, 7'h32,
                 7'h40, 7'h41, 7'h42, 7'h05, 7'h7F, 7'h22, 7'h33, 7'h43};
        for (int i = 0; i < 2; i++) m_fen[i] = '0;
        for (int i = 0; i < 3; i++) begin m_gen[i] = '0; m_dir[i] = '0; end
        void'($urandom(32'h5EED));

        repeat (4) @(negedge clk);
        chk("R1 sdo in reset", {63'h0, sdo}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check_outputs("R1 after reset");
        chk("R1 sdo after reset", {63'h0, sdo}, 64'h0);

        // R7: strobes with no clear since reset do nothing
        for (int i = 0; i < 30; i++) strobe_bit(1'b1);
        check_outputs("R7 strobes before clear");

        // R5: identification words
        do_read(7'h10, "R5 platform id");
        do_read(7'h11, "R5 firmware id");

        // R2 / R9: writes and bit positions
        do_write(7'h20, 16'h8001, 1'b1);
        check_outputs("R2 fen0 write");
        do_write(7'h32, 16'hC3A5, 1'b1);
        check_outputs("R9 gpio enable bank2");
        do_write(7'h41, 16'h0F0F, 1'b1);
        check_outputs("R9 gpio direction bank1");
        do_read(7'h20, "R4 read fen0");
        do_read(7'h41, "R4 read gdir1");

        // R3: truncated write is dropped
        do_write(7'h21, 16'hFFFF, 1'b0);
        open_access();
        check_outputs("R3 truncated write");
        do_read(7'h21, "R3 truncated readback");

        // R6: read-only and unmapped
        do_write(7'h10, 16'h1234, 1'b1);
        do_write(7'h55, 16'hBEEF, 1'b1);
        check_outputs("R6 ignored writes");
        do_read(7'h10, "R6 platform id unchanged");
        do_read(7'h55, "R6 unmapped reads zero");

        // R7: extra strobes after trailing cycle
        do_write(7'h30, 16'h00FF, 1'b1);
        for (int i = 0; i < 24; i++) strobe_bit(1'b1);
        check_outputs("R7 strobes after trail");

        // R10: clear in the middle of an address frame
        open_access();
        for (int i = 0; i < 4; i++) strobe_bit(1'b1);
        do_write(7'h31, 16'h5A5A, 1'b1);
        check_outputs("R10 write after aborted frame");
        do_read(7'h31, "R10 readback");

        // Random mix
        for (int n = 0; n < 60; n++) begin
            logic [6:0] a;
            logic [15:0] d;
            int op;
            a  = pool[$urandom_range(0, 14)];
            d  = 16'($urandom);
            op = $urandom_range(0, 9);
            if (op < 4) begin
                do_read(a, "R4 random read");
            end else begin
                do_write(a, d, op != 9);
                if (op == 9) open_access();
                check_outputs(op == 9 ? "R3 random truncated" : "R2 random write");
            end
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule